// File: doc/BRIEF.md
# Segmented ROM/RAM Bank Mapper

This block sits on the cartridge side of an 8-bit CPU bus whose cartridge window spans 0x1000 to 0x1FFF. The window is divided into eight 512-byte slots, selected by CPU address bits [11:9]. Software remaps the window by writing a single byte to one of two control addresses in low I/O space. The top two data bits of that byte name a 1 KB segment (0 to 3) and the low six bits name a bank. A write to the ROM control address places a 1 KB ROM bank across both slots of the chosen segment. A write to the RAM control address places a 512-byte RAM bank in two slots: slot N, which can only be read, and slot N+4, 0x800 higher, which can only be written.

For each CPU access the mapper produces a ROM or RAM physical address, a read select for each array, a RAM write strobe and a flag for slots that have never been mapped. For those undefined slots it also supplies free-running pseudo-random bytes that the board can return as read data. The control bytes are decoded at their exact 13-bit addresses only. A new mapping applies from the clock edge that follows the control write.

Top module: `seg_bank_mapper`

## Requirements
- R1: While reset is active and afterwards until the first control write, slots 0, 1, 6 and 7 hold ROM bank 0 and slots 2 to 5 are undefined.
- R2: A valid CPU write to address 0x003F with data bits [7:6]=s and [5:0]=b maps ROM bank b into slots 2s and 2s+1 from the next clock edge.
- R3: A valid CPU write to address 0x003E with data bits [7:6]=s and [5:0]=b maps RAM bank b into slot s as a read window and into slot s+4 as a write window from the next clock edge.
- R4: A valid read (cpu_wr=0) with A12=1 that hits a ROM slot raises rom_sel, and rom_addr equals bank*1024 + address bits [9:0].
- R5: A valid read with A12=1 that hits a RAM slot in 0 to 3 raises ram_rd, and ram_addr equals bank*512 + address bits [8:0].
- R6: ram_we is high only for a valid write (cpu_wr=1) with A12=1 into a RAM slot in 4 to 7. Writes into ROM slots or RAM read windows, and reads of RAM write windows, raise no select or strobe.
- R7: Any valid access with A12=1 to an undefined slot raises unmapped and no other select. At most one of rom_sel, ram_rd, ram_we and unmapped is high in any cycle.
- R8: The control addresses are decoded on all 13 address bits and only for valid writes. Writes to 0x103F, 0x007F, 0x00BF, 0x013F, 0x083F, 0x003D or 0x003C, reads of 0x003F and cycles with cpu_valid=0 leave the map unchanged.
- R9: A later control write replaces whatever the slots held before. This includes a RAM write that replaces half of a ROM segment.
- R10: noise_data is never zero and changes on every clock while out of reset.
- R11: Accesses with A12=0, and cycles with cpu_valid=0, raise none of rom_sel, ram_rd, ram_we or unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_valid | input | 1 | A CPU bus access is present this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 13 | CPU address bits [12:0] |
| cpu_wdata | input | 8 | CPU write data |
| rom_sel | output | 1 | ROM read select |
| ram_rd | output | 1 | RAM read select |
| ram_we | output | 1 | RAM write strobe |
| unmapped | output | 1 | Access to an undefined slot |
| rom_addr | output | 16 | Physical ROM byte address |
| ram_addr | output | 15 | Physical RAM byte address |
| noise_data | output | 8 | Pseudo-random bytes for undefined reads |

## Verification
The hardest situations to reach from the ports are overlapping mappings, where a RAM control write takes over one slot of a ROM segment and the opposite slot of another, and addresses that differ from a control address in a single bit. The bench reaches them by issuing ordered sequences of control writes, including near-miss addresses and read or idle cycles on the exact control addresses. After each group it sweeps every slot with both a read and a write, so that each window, each hole and each leftover half-segment is observed through the selects and physical addresses.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int unsigned BANK_W  = 6;
  localparam int unsigned SLOT_N  = 8;
  localparam int unsigned SLOT_IW = $clog2(SLOT_N);
  localparam int unsigned NOISE_W = 8;

  typedef struct packed {
    logic              valid;
    logic              is_ram;
    logic [BANK_W-1:0] bank;
  } slot_t;

  // Boot mapping: ROM bank 0 in the first and last segments, holes elsewhere.
  function automatic slot_t boot_slot(input int unsigned idx);
    slot_t s;
    s.valid  = (idx < 2) || (idx >= SLOT_N - 2);
    s.is_ram = 1'b0;
    s.bank   = '0;
    return s;
  endfunction
endpackage

// File: rtl/sbm_rst_sync.sv
module sbm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/sbm_hotspot_decode.sv
module sbm_hotspot_decode
  import sbm_pkg::*;
#(
  parameter logic [12:0] ROM_HOT = 13'h003F,
  parameter logic [12:0] RAM_HOT = 13'h003E
) (
  input  logic              cpu_valid,
  input  logic              cpu_wr,
  input  logic [12:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              rom_hit,
  output logic              ram_hit,
  output logic [1:0]        seg,
  output logic [BANK_W-1:0] map_bank
);
  logic wr_cyc;

  always_comb begin
    wr_cyc   = cpu_valid && cpu_wr;
    rom_hit  = wr_cyc && (cpu_addr == ROM_HOT);
    ram_hit  = wr_cyc && (cpu_addr == RAM_HOT);
    seg      = cpu_wdata[7:6];
    map_bank = cpu_wdata[BANK_W-1:0];
  end
endmodule

// File: rtl/sbm_slot_table.sv
module sbm_slot_table
  import sbm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rom_hit,
  input  logic                    ram_hit,
  input  logic [1:0]              seg,
  input  logic [BANK_W-1:0]       map_bank,
  output slot_t [SLOT_N-1:0]      slot_q
);
  slot_t [SLOT_N-1:0] slot_d;
  logic               upd_en;

  always_comb begin
    slot_d = slot_q;
    upd_en = rom_hit || ram_hit;
    if (rom_hit) begin
      slot_d[{seg, 1'b0}] = '{valid: 1'b1, is_ram: 1'b0, bank: map_bank};
      slot_d[{seg, 1'b1}] = '{valid: 1'b1, is_ram: 1'b0, bank: map_bank};
    end
    if (ram_hit) begin
      slot_d[{1'b0, seg}] = '{valid: 1'b1, is_ram: 1'b1, bank: map_bank};
      slot_d[{1'b1, seg}] = '{valid: 1'b1, is_ram: 1'b1, bank: map_bank};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < SLOT_N; i++) slot_q[i] <= boot_slot(i);
    end else if (upd_en) begin
      slot_q <= slot_d;
    end
  end

  // R2
  rom_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |=> (slot_q[{$past(seg), 1'b0}].valid && !slot_q[{$past(seg), 1'b0}].is_ram
                 && slot_q[{$past(seg), 1'b1}].bank == $past(map_bank)));
  // R3
  ram_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_hit |=> (slot_q[{1'b1, $past(seg)}].valid && slot_q[{1'b1, $past(seg)}].is_ram
                 && slot_q[{1'b0, $past(seg)}].bank == $past(map_bank)));
  // R8
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_hit || ram_hit) |=> $stable(slot_q));
endmodule

// File: rtl/sbm_noise_lfsr.sv
module sbm_noise_lfsr #(
  parameter int unsigned   W     = 8,
  parameter logic [W-1:0]  TAPS  = 8'hB8,
  parameter logic [W-1:0]  SEED  = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_q
);
  logic [W-1:0] state_d;

  always_comb begin
    state_d = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R10
  lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state_q != $past(state_q));
endmodule

// File: rtl/seg_bank_mapper.sv
module seg_bank_mapper
  import sbm_pkg::*;
#(
  parameter logic [12:0]        ROM_HOT    = 13'h003F,
  parameter logic [12:0]        RAM_HOT    = 13'h003E,
  parameter logic [NOISE_W-1:0] NOISE_SEED = 8'h5A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_valid,
  input  logic                 cpu_wr,
  input  logic [12:0]          cpu_addr,
  input  logic [7:0]           cpu_wdata,
  output logic                 rom_sel,
  output logic                 ram_rd,
  output logic                 ram_we,
  output logic                 unmapped,
  output logic [BANK_W+9:0]    rom_addr,
  output logic [BANK_W+8:0]    ram_addr,
  output logic [NOISE_W-1:0]   noise_data
);
  logic               rst_sync_n;
  logic               rom_hit, ram_hit;
  logic [1:0]         seg;
  logic [BANK_W-1:0]  map_bank;
  slot_t [SLOT_N-1:0] slot_q;
  slot_t              cur;
  logic [SLOT_IW-1:0] slot_idx;
  logic               in_win;

  sbm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  sbm_hotspot_decode #(.ROM_HOT(ROM_HOT), .RAM_HOT(RAM_HOT)) u_dec (
    .cpu_valid(cpu_valid), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rom_hit(rom_hit), .ram_hit(ram_hit), .seg(seg), .map_bank(map_bank));

  sbm_slot_table u_tab (
    .clk(clk), .rst_n(rst_sync_n), .rom_hit(rom_hit), .ram_hit(ram_hit),
    .seg(seg), .map_bank(map_bank), .slot_q(slot_q));

  sbm_noise_lfsr #(.W(NOISE_W), .TAPS(8'hB8), .SEED(NOISE_SEED)) u_noise (
    .clk(clk), .rst_n(rst_sync_n), .state_q(noise_data));

  always_comb begin
    in_win   = cpu_valid && cpu_addr[12];
    slot_idx = cpu_addr[11:9];
    cur      = slot_q[slot_idx];
    unmapped = in_win && !cur.valid;
    rom_sel  = in_win && cur.valid && !cur.is_ram && !cpu_wr;
    ram_rd   = in_win && cur.valid && cur.is_ram && !slot_idx[SLOT_IW-1] && !cpu_wr;
    ram_we   = in_win && cur.valid && cur.is_ram &&  slot_idx[SLOT_IW-1] &&  cpu_wr;
    rom_addr = {cur.bank, cpu_addr[9:0]};
    ram_addr = {cur.bank, cpu_addr[8:0]};
  end

  // R7
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({rom_sel, ram_rd, ram_we, unmapped}));
  // R11
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cpu_valid && cpu_addr[12]) |-> !(rom_sel || ram_rd || ram_we || unmapped));
endmodule

// File: tb/seg_bank_mapper_test.sv
`timescale 1ns/1ps
module seg_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid, cpu_wr;
  logic [12:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        rom_sel, ram_rd, ram_we, unmapped;
  logic [15:0] rom_addr;
  logic [14:0] ram_addr;
  logic [7:0]  noise_data;

  int checks = 0;
  int failures = 0;
  bit live = 0;
  bit have_prev = 0;
  logic [7:0] prev_noise;

  // behavioural map: one entry per 512-byte slot
  bit m_valid [8];
  bit m_ram   [8];
  int m_bank  [8];

  always #2.5 clk = ~clk;

  seg_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rom_sel(rom_sel), .ram_rd(ram_rd),
    .ram_we(ram_we), .unmapped(unmapped), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .noise_data(noise_data));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_boot();
    for (int s = 0; s < 8; s++) begin
      m_valid[s] = (s == 0 || s == 1 || s == 6 || s == 7);
      m_ram[s]   = 0;
      m_bank[s]  = 0;
    end
  endtask

  task automatic cyc(input bit v, input bit w, input int a, input int d, input string tag);
    int  s;
    bit  win;
    int  e_rom, e_rrd, e_rwe, e_unm;
    string sub;
    @(negedge clk);
    cpu_valid = v; cpu_wr = w; cpu_addr = 13'(a); cpu_wdata = 8'(d);
    #1;
    s = (a >> 9) & 7;
    win = v && ((a & 'h1000) != 0);
    e_rom = 0; e_rrd = 0; e_rwe = 0; e_unm = 0;
    sub = "R11";
    if (win) begin
      if (!m_valid[s]) begin e_unm = 1; sub = "R7"; end
      else if (m_ram[s]) begin
        sub = "R6";
        if (s >= 4 && w) e_rwe = 1;
        if (s < 4 && !w) begin e_rrd = 1; sub = "R5"; end
      end else begin
        sub = w ? "R6" : "R4";
        if (!w) e_rom = 1;
      end
    end
    chk({tag, "/", sub}, "rom_sel", int'(rom_sel), e_rom);
    chk({tag, "/", sub}, "ram_rd", int'(ram_rd), e_rrd);
    chk({tag, "/", sub}, "ram_we", int'(ram_we), e_rwe);
    chk({tag, "/", sub}, "unmapped", int'(unmapped), e_unm);
    if (e_rom == 1)
      chk({tag, "/R4"}, "rom_addr", int'(rom_addr), m_bank[s] * 1024 + (a & 'h3FF));
    if (e_rrd == 1 || e_rwe == 1)
      chk({tag, "/R5"}, "ram_addr", int'(ram_addr), m_bank[s] * 512 + (a & 'h1FF));
    if (live) begin
      chk("R10", "noise_nonzero", int'(noise_data != 8'h00), 1);
      if (have_prev) chk("R10", "noise_changes", int'(noise_data != prev_noise), 1);
      prev_noise = noise_data;
      have_prev = 1;
      // update the model for the next cycle
      if (v && w && (a == 'h003F || a == 'h003E)) begin
        int sg = (d >> 6) & 3;
        int bk = d & 63;
        if (a == 'h003F) begin
          for (int k = 0; k < 2; k++) begin
            m_valid[sg * 2 + k] = 1; m_ram[sg * 2 + k] = 0; m_bank[sg * 2 + k] = bk;
          end
        end else begin
          m_valid[sg] = 1;     m_ram[sg] = 1;     m_bank[sg] = bk;
          m_valid[sg + 4] = 1; m_ram[sg + 4] = 1; m_bank[sg + 4] = bk;
        end
      end
    end
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 8; s++) begin
      int off = (s * 37 + 300) % 512;
      cyc(1, 0, 'h1000 + s * 512 + off, 0, tag);
      cyc(1, 1, 'h1000 + s * 512 + off, s + 1, tag);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cpu_valid = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 0;
    model_boot();
    // R1: boot map visible while reset is held
    sweep("R1");
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R11");
    live = 1;
    sweep("R1");

    // R2: ROM remap of every segment
    for (int s = 0; s < 4; s++) begin
      cyc(1, 1, 'h003F, (s << 6) | (5 + 9 * s), "R2");
      cyc(1, 0, 'h1000 + s * 1024 + 3, 0, "R2");
    end
    sweep("R2");

    // R3: RAM remap of every segment, read/write windows
    for (int s = 0; s < 4; s++) begin
      cyc(1, 1, 'h003E, (s << 6) | (40 + s), "R3");
      cyc(1, 0, 'h1000 + s * 512 + 17, 0, "R3");
      cyc(1, 1, 'h1800 + s * 512 + 17, 9, "R3");
    end
    sweep("R3");

    // R8: near-miss addresses and non-write cycles
    cyc(1, 1, 'h003F, (1 << 6) | 12, "R8");
    cyc(1, 1, 'h103F, (2 << 6) | 50, "R8");
    cyc(1, 1, 'h007F, (2 << 6) | 51, "R8");
    cyc(1, 1, 'h00BF, (2 << 6) | 52, "R8");
    cyc(1, 1, 'h013F, (3 << 6) | 53, "R8");
    cyc(1, 1, 'h083F, (3 << 6) | 54, "R8");
    cyc(1, 1, 'h003D, (0 << 6) | 55, "R8");
    cyc(1, 1, 'h003C, (0 << 6) | 56, "R8");
    cyc(1, 0, 'h003F, (2 << 6) | 57, "R8");
    cyc(0, 1, 'h003E, (3 << 6) | 58, "R8");
    sweep("R8");

    // R9: overwrite, then a RAM bank splits a ROM segment
    cyc(1, 1, 'h003F, (1 << 6) | 63, "R9");
    cyc(1, 1, 'h003F, (1 << 6) | 7, "R9");
    cyc(1, 1, 'h003E, (2 << 6) | 0, "R9");
    sweep("R9");
    cyc(1, 1, 'h003F, (3 << 6) | 33, "R9");
    sweep("R9");

    // R11: accesses outside the window and idle cycles
    cyc(1, 0, 'h0800, 0, "R11");
    cyc(1, 1, 'h0FFF, 3, "R11");
    cyc(0, 0, 'h1000, 0, "R11");
    cyc(0, 1, 'h1A00, 1, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule